// File: doc/BRIEF.md
# Triggered Sample Clock Timing Engine

This block produces the sample clock for a digital input acquisition. It watches a set of timebase lines and picks one of them with a select input. The first lines are fast internal timebases. The rest are slower or external clock and trigger lines. A tick is one qualifying edge of the chosen line. The edge is rising by default, or falling when requested and the chosen line is not a fast internal one. All lines and the start trigger are brought into the system clock domain with a two-stage synchronizer. Edges are detected after the synchronizer.

Software arms the engine. A rising edge on the start trigger then starts a hold-off of a programmed number of ticks. After that the engine counts ticks down by a programmable divisor and emits one-cycle sample clock pulses. In finite mode it stops by itself after the programmed number of pulses and raises a done flag. In continuous mode it runs until a stop strobe arrives. The recommended start delay after reset is two ticks.

Top module: `dst_sample_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, samp_clk and done are 0 and the engine is idle.
- R2: tb_sel picks which of the NUM_SRC tb_lines bits supplies ticks. Edges on the other lines have no effect on samp_clk.
- R3: For tb_sel values of NUM_FAST and above, tb_falling=1 makes falling edges the ticks. For tb_sel below NUM_FAST (the fast internal timebases, indices 0 and 1 by default), only rising edges are ticks, whatever tb_falling is.
- R4: Take a tick or start-trigger edge whose new level is first sampled at clock edge k. The engine acts on it at edge k+2. A resulting pulse shows on samp_clk after edge k+2 and lasts exactly one cycle.
- R5: In the run phase a pulse is issued every D ticks, where D = max(div_val, 1).
- R6: After an accepted trigger, start_dly ticks are skipped and the pulse comes on the next tick. With start_dly = 0, the first tick after the trigger gives the first pulse.
- R7: A start-trigger rising edge is accepted only while the engine is armed and waiting. arm is accepted only while the engine is idle or finished. At other times arm has no effect.
- R8: With continuous = 0, the engine issues exactly max(samp_count, 1) pulses and then stops. done rises on the same clock edge as the last pulse.
- R9: With continuous = 1, pulses continue until stop, and done never rises.
- R10: stop in any state returns the engine to idle at that clock edge. No pulse is issued at that edge, and stop leaves done unchanged.
- R11: Once set, done stays at 1 until an accepted arm clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_lines | input | NUM_SRC | Candidate timebase lines, asynchronous |
| tb_sel | input | SEL_W | Index of the timebase line in use |
| tb_falling | input | 1 | Tick on falling edges (slow and external lines only) |
| div_val | input | DIV_W | Ticks per sample clock pulse (0 acts as 1) |
| start_dly | input | DLY_W | Ticks skipped between trigger and first pulse |
| samp_count | input | CNT_W | Pulses in finite mode (0 acts as 1) |
| continuous | input | 1 | 1: run until stop; 0: finite count |
| start_trig | input | 1 | Start trigger line, asynchronous, rising edge |
| arm | input | 1 | Arm strobe |
| stop | input | 1 | Stop strobe |
| samp_clk | output | 1 | One-cycle sample clock pulse |
| done | output | 1 | Finite acquisition completed |

## Verification
Timebase and trigger edges pass through two synchronizer stages. A pulse caused by an edge first captured at clock edge k is therefore registered on samp_clk at edge k+2. arm and stop act on the very edge that samples them. The bench drives every input at a falling clock edge and feeds its reference model the tick and trigger events through a two-entry delay line, while arm and stop enter undelayed. It compares samp_clk and done at the next falling edge against the model's prediction for the rising edge in between.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int DEF_NUM_SRC  = 8;
    localparam int DEF_NUM_FAST = 2;
    localparam int DEF_DIV_W    = 8;
    localparam int DEF_DLY_W    = 8;
    localparam int DEF_CNT_W    = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_DELAY = 3'd2,
        ST_RUN   = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    // Fast internal sources sit at the lowest indices and are locked to rising edges.
    function automatic logic edge_is_falling(input int sel, input int num_fast,
                                             input logic want_fall);
        return want_fall && (sel >= num_fast);
    endfunction

endpackage

// File: rtl/dst_sync.sv
module dst_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1, stage2, stage3;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            stage3 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign cur  = stage2;
    assign prev = stage3;
endmodule

// File: rtl/dst_tick_pick.sv
module dst_tick_pick #(
    parameter int NUM_SRC  = dst_pkg::DEF_NUM_SRC,
    parameter int NUM_FAST = dst_pkg::DEF_NUM_FAST,
    localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] cur,
    input  logic [NUM_SRC-1:0] prev,
    input  logic [SEL_W-1:0]   sel,
    input  logic               want_fall,
    output logic               tick
);
    logic now_lvl, old_lvl, use_fall;

    always_comb begin
        now_lvl  = cur[sel];
        old_lvl  = prev[sel];
        use_fall = dst_pkg::edge_is_falling(int'(sel), NUM_FAST, want_fall);
        tick     = use_fall ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
    end
endmodule

// File: rtl/dst_seq.sv
module dst_seq
    import dst_pkg::*;
#(
    parameter int DIV_W = DEF_DIV_W,
    parameter int DLY_W = DEF_DLY_W,
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             stop,
    input  logic             trig_pulse,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_val,
    input  logic [DLY_W-1:0] start_dly,
    input  logic [CNT_W-1:0] samp_count,
    input  logic             continuous,
    output logic             samp_clk,
    output logic             done,
    output seq_state_e       state
);
    logic [DIV_W-1:0] div_cnt;
    logic [DLY_W-1:0] dly_cnt;
    logic [CNT_W-1:0] issued;
    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] cnt_eff;
    logic [CNT_W-1:0] issued_nx;

    always_comb begin
        div_eff   = (div_val == '0) ? DIV_W'(1) : div_val;
        cnt_eff   = (samp_count == '0) ? CNT_W'(1) : samp_count;
        issued_nx = issued + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            div_cnt  <= '0;
            dly_cnt  <= '0;
            issued   <= '0;
            samp_clk <= 1'b0;
            done     <= 1'b0;
        end else begin
            samp_clk <= 1'b0;
            if (stop) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE, ST_DONE: begin
                        if (arm) begin
                            state <= ST_ARMED;
                            done  <= 1'b0;
                        end
                    end
                    ST_ARMED: begin
                        if (trig_pulse) begin
                            issued  <= '0;
                            div_cnt <= '0;
                            dly_cnt <= start_dly;
                            state   <= (start_dly == '0) ? ST_RUN : ST_DELAY;
                        end
                    end
                    ST_DELAY: begin
                        if (tick) begin
                            dly_cnt <= dly_cnt - DLY_W'(1);
                            if (dly_cnt == DLY_W'(1)) state <= ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (tick) begin
                            if (div_cnt == '0) begin
                                samp_clk <= 1'b1;
                                div_cnt  <= div_eff - DIV_W'(1);
                                issued   <= issued_nx;
                                if (!continuous && issued_nx == cnt_eff) begin
                                    state <= ST_DONE;
                                    done  <= 1'b1;
                                end
                            end else begin
                                div_cnt <= div_cnt - DIV_W'(1);
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dst_sample_timer.sv
module dst_sample_timer
    import dst_pkg::*;
#(
    parameter int NUM_SRC  = DEF_NUM_SRC,
    parameter int NUM_FAST = DEF_NUM_FAST,
    parameter int DIV_W    = DEF_DIV_W,
    parameter int DLY_W    = DEF_DLY_W,
    parameter int CNT_W    = DEF_CNT_W,
    localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] tb_lines,
    input  logic [SEL_W-1:0]   tb_sel,
    input  logic               tb_falling,
    input  logic [DIV_W-1:0]   div_val,
    input  logic [DLY_W-1:0]   start_dly,
    input  logic [CNT_W-1:0]   samp_count,
    input  logic               continuous,
    input  logic               start_trig,
    input  logic               arm,
    input  logic               stop,
    output logic               samp_clk,
    output logic               done
);
    logic [NUM_SRC-1:0] line_cur, line_prev;
    logic [0:0]         trig_cur, trig_prev;
    logic               tick;
    logic               trig_pulse;
    seq_state_e         seq_state;

    dst_sync #(.W(NUM_SRC)) u_line_sync (
        .clk(clk), .rst(rst), .async_in(tb_lines), .cur(line_cur), .prev(line_prev)
    );

    dst_sync #(.W(1)) u_trig_sync (
        .clk(clk), .rst(rst), .async_in(start_trig), .cur(trig_cur), .prev(trig_prev)
    );

    assign trig_pulse = trig_cur[0] & ~trig_prev[0];

    dst_tick_pick #(.NUM_SRC(NUM_SRC), .NUM_FAST(NUM_FAST)) u_pick (
        .cur(line_cur), .prev(line_prev), .sel(tb_sel), .want_fall(tb_falling), .tick(tick)
    );

    dst_seq #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .arm(arm), .stop(stop), .trig_pulse(trig_pulse),
        .tick(tick), .div_val(div_val), .start_dly(start_dly),
        .samp_count(samp_count), .continuous(continuous),
        .samp_clk(samp_clk), .done(done), .state(seq_state)
    );
endmodule

// File: rtl/dst_sample_timer_chk.sv
module dst_sample_timer_chk
    import dst_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       arm,
    input logic       stop,
    input logic       continuous,
    input logic       trig_pulse,
    input logic       tick,
    input logic       samp_clk,
    input logic       done,
    input seq_state_e state
);
    assert_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        samp_clk |=> !samp_clk);

    assert_pulse_from_run_R5: assert property (@(posedge clk) disable iff (rst)
        samp_clk |-> ($past(state) == ST_RUN && $past(tick)));

    assert_trig_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DELAY) |-> ($past(state) == ST_ARMED || $past(state) == ST_DELAY));

    assert_armed_waits_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && !trig_pulse && !stop) |=> (state == ST_ARMED));

    assert_done_finite_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!$past(continuous) && $past(state) == ST_RUN));

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
        stop |=> (state == ST_IDLE && !samp_clk));

    assert_done_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> done);
endmodule

bind dst_sample_timer dst_sample_timer_chk u_chk (
    .clk(clk), .rst(rst), .arm(arm), .stop(stop), .continuous(continuous),
    .trig_pulse(trig_pulse), .tick(tick), .samp_clk(samp_clk), .done(done),
    .state(seq_state)
);

// File: tb/tb_dst_sample_timer.sv
module tb_dst_sample_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC  = 8;
    localparam int NUM_FAST = 2;
    localparam int SEL_W = 3;
    localparam int DIV_W = 8;
    localparam int DLY_W = 8;
    localparam int CNT_W = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] tb_lines = '0;
    logic [SEL_W-1:0]   tb_sel = '0;
    logic               tb_falling = 1'b0;
    logic [DIV_W-1:0]   div_val = '0;
    logic [DLY_W-1:0]   start_dly = '0;
    logic [CNT_W-1:0]   samp_count = '0;
    logic               continuous = 1'b0;
    logic               start_trig = 1'b0;
    logic               arm = 1'b0;
    logic               stop = 1'b0;
    logic               samp_clk, done;

    dst_sample_timer dut (
        .clk(clk), .rst(rst), .tb_lines(tb_lines), .tb_sel(tb_sel),
        .tb_falling(tb_falling), .div_val(div_val), .start_dly(start_dly),
        .samp_count(samp_count), .continuous(continuous), .start_trig(start_trig),
        .arm(arm), .stop(stop), .samp_clk(samp_clk), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // reference model state (0 idle, 1 armed, 2 delay, 3 run, 4 done)
    int m_st = 0;
    int m_dleft = 0, m_divc = 0, m_issued = 0;
    bit m_done = 0, exp_clk = 0, exp_done = 0, have_exp = 0;
    bit tk_h1 = 0, tk_h2 = 0, tg_h1 = 0, tg_h2 = 0;
    logic [NUM_SRC-1:0] raw_prev = '0;
    bit trig_prev = 0;

    // next-drive values
    logic [NUM_SRC-1:0] n_lines = '0;
    bit n_trig = 0, n_arm = 0, n_stop = 0;
    int sel_hp = 2, sel_phase = 0;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic bit tick_of(input logic [NUM_SRC-1:0] prv, input logic [NUM_SRC-1:0] cur,
                                   input int sel, input bit fall);
        bit use_fall;
        use_fall = fall && (sel >= NUM_FAST);
        return use_fall ? (prv[sel] & ~cur[sel]) : (cur[sel] & ~prv[sel]);
    endfunction

    task automatic model_step(input bit a, input bit s, input bit tk, input bit tg);
        exp_clk = 0;
        if (s) m_st = 0;
        else begin
            case (m_st)
                0, 4: if (a) begin m_st = 1; m_done = 0; end
                1: if (tg) begin
                       m_issued = 0; m_divc = 0; m_dleft = int'(start_dly);
                       m_st = (start_dly == 0) ? 3 : 2;
                   end
                2: if (tk) begin m_dleft--; if (m_dleft == 0) m_st = 3; end
                3: if (tk) begin
                       if (m_divc == 0) begin
                           exp_clk = 1;
                           m_divc = eff(int'(div_val)) - 1;
                           m_issued++;
                           if (!continuous && m_issued == eff(int'(samp_count))) begin
                               m_st = 4; m_done = 1;
                           end
                       end else m_divc--;
                   end
                default: m_st = 0;
            endcase
        end
        exp_done = m_done;
    endtask

    task automatic cycle();
        bit tk_now, tg_now;
        @(negedge clk);
        if (have_exp) begin
            vectors++;
            if (samp_clk !== exp_clk) begin
                miscompares++;
                $display("FAIL R2 R3 R4 R5 R6 R7 R8 R9 R10 samp_clk actual=%b expected=%b t=%0t",
                         samp_clk, exp_clk, $time);
            end
            vectors++;
            if (done !== exp_done) begin
                miscompares++;
                $display("FAIL R8 R9 R10 R11 done actual=%b expected=%b t=%0t",
                         done, exp_done, $time);
            end
        end
        tb_lines = n_lines; start_trig = n_trig; arm = n_arm; stop = n_stop;
        tk_now = tick_of(raw_prev, n_lines, int'(tb_sel), tb_falling);
        tg_now = n_trig & ~trig_prev;
        raw_prev = n_lines; trig_prev = n_trig;
        model_step(n_arm, n_stop, tk_h2, tg_h2);
        tk_h2 = tk_h1; tk_h1 = tk_now;
        tg_h2 = tg_h1; tg_h1 = tg_now;
        have_exp = 1;
    endtask

    // selected line is a square wave; the others carry random noise (R2)
    task automatic next_lines();
        logic [NUM_SRC-1:0] noise;
        noise = NUM_SRC'($urandom);
        sel_phase++;
        if (sel_phase >= sel_hp) begin
            sel_phase = 0;
            noise[tb_sel] = ~n_lines[tb_sel];
        end else noise[tb_sel] = n_lines[tb_sel];
        n_lines = noise;
    endtask

    task automatic run_scn(input int sel, input bit fall, input int dv, input int dl,
                           input int cnt, input bit cont, input int hp, input int len);
        n_arm = 0; n_stop = 0;
        tb_sel = SEL_W'(sel); tb_falling = fall; div_val = DIV_W'(dv);
        start_dly = DLY_W'(dl); samp_count = CNT_W'(cnt); continuous = cont;
        sel_hp = hp;
        // trigger while idle must be ignored (R7)
        for (int i = 0; i < 6; i++) begin
            next_lines(); n_trig = (i == 1 || i == 2); cycle();
        end
        n_trig = 0;
        for (int i = 0; i < 3; i++) begin next_lines(); cycle(); end
        next_lines(); n_arm = 1; cycle(); n_arm = 0;
        for (int i = 0; i < 2 + ($urandom % 4); i++) begin next_lines(); cycle(); end
        for (int i = 0; i < len; i++) begin
            next_lines();
            n_trig = (i < 3) ? 1'b1 : (($urandom % 25) == 0) ? ~n_trig : n_trig;
            n_arm  = (i > 5) && (($urandom % 70) == 0);
            n_stop = (i > 5) && (($urandom % 180) == 0);
            cycle();
        end
        n_arm = 0; n_trig = 0; n_stop = 1; next_lines(); cycle(); n_stop = 0;
        for (int i = 0; i < 3; i++) begin next_lines(); cycle(); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        vectors++;
        if (samp_clk !== 1'b0 || done !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset actual=%b%b expected=00", samp_clk, done);
        end
        rst = 1'b0;
        cycle();
        vectors++;
        if (samp_clk !== 1'b0 || done !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 post-reset actual=%b%b expected=00", samp_clk, done);
        end
        // directed corners
        run_scn(0, 1, 1, 0, 3, 0, 2, 60);   // R3 fast source locks rising, R6 delay 0
        run_scn(1, 1, 2, 2, 4, 0, 3, 120);  // R3 second fast source
        run_scn(5, 1, 3, 2, 4, 0, 2, 150);  // R3 falling on slow line, R5 divide by 3
        run_scn(6, 0, 0, 0, 0, 0, 2, 60);   // R5 divisor 0, R8 count 0 acts as 1
        run_scn(3, 0, 2, 1, 0, 1, 2, 200);  // R9 continuous until stop
        run_scn(7, 1, 1, 5, 2, 0, 4, 150);  // R6 longer hold-off
        // constrained random
        for (int s = 0; s < 40; s++) begin
            run_scn(int'($urandom % NUM_SRC), 1'($urandom), int'($urandom % 5),
                    int'($urandom % 4), int'($urandom % 6), (($urandom % 4) == 0),
                    1 + int'($urandom % 4), 80 + int'($urandom % 120));
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule